// File: doc/BRIEF.md
# Message-Signaled Interrupt File

This block is the per-hart receiver for message-signaled interrupts. A device signals an interrupt by writing an identity number as a 32-bit value into the block's message page. The block stores one pending bit and one enable bit per identity. It continuously selects the lowest-numbered identity that is both pending and enabled, and raises an external-interrupt request to the core when that identity is allowed through.

The core reaches the storage through an indirect pair of registers. It first writes a select register with a register index. It then issues a data operation on the chosen register: read, write, bit-set, bit-clear or read-and-clear. Each operation returns the value the register held before the operation. Two control registers are reached the same way: a delivery switch and a priority threshold. The core claims the current top identity with a single-cycle claim strobe. The claim returns the identity number and clears its pending bit.

The pending and enable bits are packed into 64-bit words, so one word covers 64 identities. Word indices advance in steps of two.

Top module: `msi_intr_file`

## Requirements
- R1: A data operation acts on the register named by the most recent select write. The value that register held before the operation appears on csr_rdata one clock edge after the request and holds until the next request.
- R2: Operation codes are 0 read, 1 write (replace), 2 set (OR with csr_wdata), 3 clear (AND with the inverse of csr_wdata) and 4 read-and-clear. Codes 5 to 7 behave as read and change nothing.
- R3: Pending word w sits at select PEND_BASE+2w (default 0x80) and enable word w at EN_BASE+2w (default 0xC0). Identity id lives in word id/64 at bit id mod 64.
- R4: Identity 0 is not implemented. Its pending bit and its enable bit always read 0, and writes to them are dropped.
- R5: A message write of value N sets pending bit N when 1 ≤ N ≤ NUM_IDS, one edge after the write. Any other value changes nothing.
- R6: Read-and-clear on a pending word returns the old word and clears exactly the bits set in csr_wdata, in the same operation.
- R7: Delivery is bit 0 of select DELIV_SEL (default 0x70). The threshold is the low ID bits of select THR_SEL (default 0x72). Every other select reads 0 and ignores writes, including odd indices and words beyond the implemented range.
- R8: top_id shows the lowest identity that is both pending and enabled, or 0 if there is none. It updates one edge after the state changes.
- R9: irq is 1 exactly when delivery is 1, top_id is nonzero, and either the threshold is 0 or top_id is below the threshold. A threshold of 1 therefore masks everything.
- R10: A claim loads claim_id with the current top identity and clears that pending bit. When no identity qualifies, claim_id becomes 0 and the state does not change.
- R11: When a message write sets a pending bit in the same cycle as a data-port clear or a claim clears it, the bit ends up set.
- R12: After reset, all pending bits, enable bits, delivery, threshold, select, csr_rdata, claim_id, top_id and irq are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_we | input | 1 | Message write strobe |
| msi_data | input | 32 | Identity number carried by the message |
| sel_we | input | 1 | Select register write strobe |
| sel_wdata | input | SEL_W | New select index |
| csr_req | input | 1 | Data operation request |
| csr_op | input | 3 | Operation code |
| csr_wdata | input | 64 | Operand / bit mask |
| csr_rdata | output | 64 | Pre-operation value of the selected register |
| claim_req | input | 1 | Claim strobe |
| claim_id | output | clog2(NUM_IDS+1) | Identity taken by the last claim |
| top_id | output | clog2(NUM_IDS+1) | Lowest pending and enabled identity |
| irq | output | 1 | External interrupt request |

## Verification
State registers change on the edge that samples a stimulus. csr_rdata and claim_id are therefore valid one edge after their request, while top_id and irq follow one edge later because they are registered from that state. The bench drives inputs on falling edges and reads csr_rdata and claim_id at the falling edge right after the consuming edge. It checks top_id and irq only after one further edge has passed. Register contents are always read back through a fresh select-then-read sequence, which leaves several edges between a stimulus and its check.

// File: rtl/msif_pkg.sv
package msif_pkg;
  localparam int WORD_W = 64;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SET   = 3'd2,
    OP_CLEAR = 3'd3,
    OP_RDCLR = 3'd4
  } csr_op_e;

  // New value of a register word under one data-port operation.
  function automatic logic [WORD_W-1:0] apply_op(input logic [2:0] op,
                                                 input logic [WORD_W-1:0] cur,
                                                 input logic [WORD_W-1:0] wd);
    logic [WORD_W-1:0] r;
    case (op)
      OP_WRITE:          r = wd;
      OP_SET:            r = cur | wd;
      OP_CLEAR, OP_RDCLR: r = cur & ~wd;
      default:           r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/msif_lowest.sv
module msif_lowest #(
  parameter int NBITS = 64,
  parameter int ID_W  = 6
) (
  input  logic [NBITS-1:0] vec,
  output logic [ID_W-1:0]  id,
  output logic             found
);
  always_comb begin
    id = '0;
    for (int i = NBITS - 1; i >= 0; i--) begin
      if (vec[i]) id = ID_W'(i);
    end
  end

  assign found = (id != '0);
endmodule

// File: rtl/msif_bitfile.sv
module msif_bitfile
  import msif_pkg::*;
#(
  parameter int NW   = 1,
  parameter int WI_W = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_en,
  input  logic [WI_W-1:0]      acc_word,
  input  logic [2:0]           acc_op,
  input  logic [WORD_W-1:0]    acc_wdata,
  input  logic [NW*WORD_W-1:0] ev_set,
  input  logic [NW*WORD_W-1:0] ev_clr,
  output logic [NW*WORD_W-1:0] bits_o
);
  localparam int NBITS = NW * WORD_W;

  logic [NBITS-1:0] bits_q;
  logic [NW-1:0][WORD_W-1:0] nxt_w;
  logic [NBITS-1:0] nxt_flat;

  generate
    for (genvar w = 0; w < NW; w++) begin : g_word
      logic              hit;
      logic [WORD_W-1:0] upd;
      assign hit = acc_en && (acc_word == WI_W'(w));
      assign upd = hit ? apply_op(acc_op, bits_q[w*WORD_W +: WORD_W], acc_wdata)
                       : bits_q[w*WORD_W +: WORD_W];
      // Clears apply first, message sets last, so a set always wins.
      assign nxt_w[w] = (upd & ~ev_clr[w*WORD_W +: WORD_W]) | ev_set[w*WORD_W +: WORD_W];
    end
  endgenerate

  // Bit 0 stands for identity 0, which has no storage.
  assign nxt_flat = nxt_w & ~NBITS'(1);

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= nxt_flat;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/msif_regport.sv
module msif_regport
  import msif_pkg::*;
#(
  parameter int NW        = 1,
  parameter int WI_W      = 1,
  parameter int ID_W      = 6,
  parameter int SEL_W     = 8,
  parameter int PEND_BASE = 128,
  parameter int EN_BASE   = 192,
  parameter int DELIV_SEL = 112,
  parameter int THR_SEL   = 114
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_we,
  input  logic [SEL_W-1:0]     sel_wdata,
  input  logic                 req,
  input  logic [2:0]           op,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [NW*WORD_W-1:0] pend_bits,
  input  logic [NW*WORD_W-1:0] en_bits,
  output logic                 pend_acc,
  output logic                 en_acc,
  output logic [WI_W-1:0]      acc_word,
  output logic [WORD_W-1:0]    rdata,
  output logic                 deliv,
  output logic [ID_W-1:0]      thr
);
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] rdata_q;
  logic              deliv_q;
  logic [ID_W-1:0]   thr_q;

  logic [31:0] off_p, off_e;
  logic        pend_in, en_in, deliv_hit, thr_hit;
  logic [NW-1:0][WORD_W-1:0] pend_w, en_w;
  logic [WORD_W-1:0] rd_val;
  logic              deliv_nxt;
  logic [ID_W-1:0]   thr_nxt;

  // Word decode: an underflowed offset is huge and fails the range test.
  assign off_p   = 32'(sel_q) - 32'(PEND_BASE);
  assign off_e   = 32'(sel_q) - 32'(EN_BASE);
  assign pend_in = (off_p < 32'(2 * NW)) && !off_p[0];
  assign en_in   = (off_e < 32'(2 * NW)) && !off_e[0];
  assign deliv_hit = (32'(sel_q) == 32'(DELIV_SEL));
  assign thr_hit   = (32'(sel_q) == 32'(THR_SEL));
  assign acc_word  = pend_in ? off_p[WI_W:1] : off_e[WI_W:1];

  assign pend_acc = req && pend_in;
  assign en_acc   = req && en_in;

  assign pend_w = pend_bits;
  assign en_w   = en_bits;

  always_comb begin
    if (pend_in)        rd_val = pend_w[acc_word];
    else if (en_in)     rd_val = en_w[acc_word];
    else if (deliv_hit) rd_val = {{(WORD_W-1){1'b0}}, deliv_q};
    else if (thr_hit)   rd_val = WORD_W'(thr_q);
    else                rd_val = '0;
  end

  always_comb begin
    case (op)
      OP_WRITE:           deliv_nxt = wdata[0];
      OP_SET:             deliv_nxt = deliv_q | wdata[0];
      OP_CLEAR, OP_RDCLR: deliv_nxt = deliv_q & ~wdata[0];
      default:            deliv_nxt = deliv_q;
    endcase
  end

  always_comb begin
    case (op)
      OP_WRITE:           thr_nxt = wdata[ID_W-1:0];
      OP_SET:             thr_nxt = thr_q | wdata[ID_W-1:0];
      OP_CLEAR, OP_RDCLR: thr_nxt = thr_q & ~wdata[ID_W-1:0];
      default:            thr_nxt = thr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      rdata_q <= '0;
      deliv_q <= 1'b0;
      thr_q   <= '0;
    end else begin
      if (sel_we) sel_q <= sel_wdata;
      if (req) begin
        rdata_q <= rd_val;
        if (deliv_hit) deliv_q <= deliv_nxt;
        if (thr_hit)   thr_q   <= thr_nxt;
      end
    end
  end

  assign rdata = rdata_q;
  assign deliv = deliv_q;
  assign thr   = thr_q;

  // R7: the control registers only move under a request that selects them
  a_r7_ctrl_guarded: assert property (@(posedge clk) disable iff (rst)
    !(req && (deliv_hit || thr_hit)) |=> $stable(deliv_q) && $stable(thr_q));
endmodule

// File: rtl/msi_intr_file.sv
module msi_intr_file
  import msif_pkg::*;
#(
  parameter int NUM_IDS   = 63,
  parameter int SEL_W     = 8,
  parameter int PEND_BASE = 128,
  parameter int EN_BASE   = 192,
  parameter int DELIV_SEL = 112,
  parameter int THR_SEL   = 114
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             msi_we,
  input  logic [31:0]                      msi_data,
  input  logic                             sel_we,
  input  logic [SEL_W-1:0]                 sel_wdata,
  input  logic                             csr_req,
  input  logic [2:0]                       csr_op,
  input  logic [63:0]                      csr_wdata,
  output logic [63:0]                      csr_rdata,
  input  logic                             claim_req,
  output logic [$clog2(NUM_IDS+1)-1:0]     claim_id,
  output logic [$clog2(NUM_IDS+1)-1:0]     top_id,
  output logic                             irq
);
  localparam int NW    = (NUM_IDS + 1) / WORD_W;
  localparam int NBITS = NW * WORD_W;
  localparam int ID_W  = $clog2(NBITS);
  localparam int WI_W  = (NW > 1) ? $clog2(NW) : 1;

  logic [NBITS-1:0] pend_bits, en_bits, msi_set, claim_clr, ready;
  logic             pend_acc, en_acc;
  logic [WI_W-1:0]  acc_word;
  logic             deliv;
  logic [ID_W-1:0]  thr;
  logic [ID_W-1:0]  cur_top;
  logic             cur_found;
  logic             msi_ok;

  logic [ID_W-1:0]  top_q, claim_q;
  logic             irq_q;

  msif_regport #(
    .NW(NW), .WI_W(WI_W), .ID_W(ID_W), .SEL_W(SEL_W),
    .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
    .DELIV_SEL(DELIV_SEL), .THR_SEL(THR_SEL)
  ) u_port (
    .clk(clk), .rst(rst),
    .sel_we(sel_we), .sel_wdata(sel_wdata),
    .req(csr_req), .op(csr_op), .wdata(csr_wdata),
    .pend_bits(pend_bits), .en_bits(en_bits),
    .pend_acc(pend_acc), .en_acc(en_acc), .acc_word(acc_word),
    .rdata(csr_rdata), .deliv(deliv), .thr(thr)
  );

  assign msi_ok  = msi_we && (msi_data >= 32'd1) && (msi_data <= 32'(NUM_IDS));
  assign msi_set = msi_ok ? (NBITS'(1) << msi_data[ID_W-1:0]) : '0;

  msif_bitfile #(.NW(NW), .WI_W(WI_W)) u_pend (
    .clk(clk), .rst(rst),
    .acc_en(pend_acc), .acc_word(acc_word), .acc_op(csr_op), .acc_wdata(csr_wdata),
    .ev_set(msi_set), .ev_clr(claim_clr), .bits_o(pend_bits)
  );

  msif_bitfile #(.NW(NW), .WI_W(WI_W)) u_en (
    .clk(clk), .rst(rst),
    .acc_en(en_acc), .acc_word(acc_word), .acc_op(csr_op), .acc_wdata(csr_wdata),
    .ev_set('0), .ev_clr('0), .bits_o(en_bits)
  );

  assign ready = pend_bits & en_bits;

  msif_lowest #(.NBITS(NBITS), .ID_W(ID_W)) u_pick (
    .vec(ready), .id(cur_top), .found(cur_found)
  );

  assign claim_clr = (claim_req && cur_found) ? (NBITS'(1) << cur_top) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q   <= '0;
      claim_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      top_q <= cur_top;
      irq_q <= deliv && cur_found && ((thr == '0) || (cur_top < thr));
      if (claim_req) claim_q <= cur_top;
    end
  end

  assign top_id   = top_q;
  assign claim_id = claim_q;
  assign irq      = irq_q;

  // R5: an in-range message lands in the pending word
  a_r5_msi_sets: assert property (@(posedge clk) disable iff (rst)
    msi_ok |=> pend_bits[$past(msi_data[ID_W-1:0])]);

  // R5: an out-of-range message alone leaves pending state untouched
  a_r5_out_of_range_ignored: assert property (@(posedge clk) disable iff (rst)
    (msi_we && !msi_ok && !csr_req && !claim_req) |=> $stable(pend_bits));

  // R8: a reported top identity was pending and enabled in the prior cycle
  a_r8_top_qualifies: assert property (@(posedge clk) disable iff (rst)
    (top_q != '0) |-> ((($past(ready) >> top_q) & NBITS'(1)) != '0));

  // R9: no request while delivery was off
  a_r9_needs_delivery: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(deliv));

  // R9: a nonzero threshold lets only smaller identities through
  a_r9_threshold: assert property (@(posedge clk) disable iff (rst)
    (irq_q && ($past(thr) != '0)) |-> (top_q < $past(thr)));

  // R10: a claimed identity is cleared unless a same-cycle write put it back
  a_r10_claim_clears: assert property (@(posedge clk) disable iff (rst)
    claim_req |=> ((claim_q == '0) || !pend_bits[claim_q] ||
                   $past(msi_we) || $past(csr_req)));
endmodule

// File: tb/msi_intr_file_bench.sv
`timescale 1ns/1ps
module msi_intr_file_bench;
  localparam int ID_W = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msi_we = 1'b0;
  logic [31:0] msi_data = '0;
  logic        sel_we = 1'b0;
  logic [7:0]  sel_wdata = '0;
  logic        csr_req = 1'b0;
  logic [2:0]  csr_op = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        claim_req = 1'b0;
  logic [ID_W-1:0] claim_id, top_id;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  msi_intr_file u_msi_intr_file (
    .clk(clk), .rst(rst),
    .msi_we(msi_we), .msi_data(msi_data),
    .sel_we(sel_we), .sel_wdata(sel_wdata),
    .csr_req(csr_req), .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .claim_req(claim_req), .claim_id(claim_id), .top_id(top_id), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic sel(input int s);
    @(negedge clk); sel_we = 1'b1; sel_wdata = 8'(s);
    @(negedge clk); sel_we = 1'b0;
  endtask

  task automatic csr(input int o, input logic [63:0] wd);
    @(negedge clk); csr_req = 1'b1; csr_op = 3'(o); csr_wdata = wd;
    @(negedge clk); csr_req = 1'b0;
  endtask

  task automatic rd(input int s, output logic [63:0] v);
    sel(s); csr(0, '0); v = csr_rdata;
  endtask

  task automatic wr(input int s, input logic [63:0] v);
    sel(s); csr(1, v);
  endtask

  task automatic msi(input logic [31:0] n);
    @(negedge clk); msi_we = 1'b1; msi_data = n;
    @(negedge clk); msi_we = 1'b0;
  endtask

  task automatic claim();
    @(negedge clk); claim_req = 1'b1;
    @(negedge clk); claim_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v, a, b, c, p, m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();

    // R12 reset state
    chk("R12 top_id", 64'(top_id), 0);
    chk("R12 irq", 64'(irq), 0);
    chk("R12 claim_id", 64'(claim_id), 0);
    chk("R12 csr_rdata", csr_rdata, 0);
    rd(8'h80, v); chk("R12 pending", v, 0);
    rd(8'hC0, v); chk("R12 enable", v, 0);
    rd(8'h70, v); chk("R12 delivery", v, 0);
    rd(8'h72, v); chk("R12 threshold", v, 0);

    // R5 R3 R4 sweep of message values
    for (int n = 0; n <= 70; n++) begin
      msi(32'(n));
      rd(8'h80, v);
      chk($sformatf("R5 msi %0d", n), v, (n >= 1 && n <= 63) ? (64'd1 << n) : 64'd0);
      wr(8'h80, '0);
    end
    msi(32'h0001_0005);
    rd(8'h80, v); chk("R5 high bits out of range", v, 0);

    // R1 R2 R4 operations on the enable word
    a = 64'hF0F0_0000_1234_5671;
    b = 64'h0000_FF00_0000_0008;
    c = 64'h00F0_0F00_0000_0060;
    sel(8'hC0);
    csr(1, a); chk("R1 write returns old", csr_rdata, 0);
    csr(2, b); chk("R4 bit0 dropped on write", csr_rdata, a & ~64'd1);
    csr(3, c); chk("R2 set ORs", csr_rdata, (a | b) & ~64'd1);
    csr(0, '1); chk("R2 clear masks", csr_rdata, ((a | b) & ~c) & ~64'd1);
    csr(7, '1); chk("R2 code 7 reads", csr_rdata, ((a | b) & ~c) & ~64'd1);
    csr(5, '0); chk("R2 code 7 no change", csr_rdata, ((a | b) & ~c) & ~64'd1);
    csr(2, 64'd1); csr(0, '0); chk("R4 bit0 set dropped", csr_rdata[0], 0);

    // R6 read-and-clear on pending
    p = 64'hA5A5_5A5A_0F0F_F0F0;
    m = 64'h00FF_00FF_0000_FFF0;
    wr(8'h80, p);
    csr(4, m); chk("R6 rdclr returns old", csr_rdata, p);
    csr(0, '0); chk("R6 rdclr clears mask only", csr_rdata, p & ~m);

    // R7 unimplemented selects and control registers
    wr(8'h80, 64'h1234_0000_0000_0010);
    rd(8'h81, v); chk("R7 odd select reads 0", v, 0);
    wr(8'h81, '1);
    rd(8'h80, v); chk("R7 odd select write ignored", v, 64'h1234_0000_0000_0010);
    wr(8'h82, '1);
    rd(8'h82, v); chk("R7 beyond range reads 0", v, 0);
    rd(8'h80, v); chk("R7 beyond range write ignored", v, 64'h1234_0000_0000_0010);
    wr(8'hC1, '1);
    rd(8'hC0, v); chk("R7 odd enable select ignored", v, ((a | b) & ~c) & ~64'd1);
    wr(8'h55, '1); rd(8'h55, v); chk("R7 undefined select reads 0", v, 0);
    wr(8'h70, 64'hFF); rd(8'h70, v); chk("R7 delivery bit0", v, 1);
    wr(8'h72, 64'h1FF); rd(8'h72, v); chk("R7 threshold width", v, 64'h3F);
    wr(8'h70, 0); wr(8'h72, 0);

    // R8 priority sweep
    wr(8'h80, '1);
    wr(8'hC0, '0); settle();
    chk("R8 none enabled", 64'(top_id), 0);
    for (int k = 1; k <= 63; k++) begin
      wr(8'hC0, ~((64'd1 << k) - 64'd1));
      settle();
      chk($sformatf("R8 lowest is %0d", k), 64'(top_id), 64'(k));
    end
    wr(8'hC0, 64'h8000_0000_0000_0000); wr(8'h80, 64'h7FFF_FFFF_FFFF_FFFF); settle();
    chk("R8 enabled but not pending", 64'(top_id), 0);

    // R9 threshold and delivery
    wr(8'h80, 64'd1 << 5);
    wr(8'hC0, '1);
    wr(8'h72, 0); settle();
    chk("R9 delivery off", 64'(irq), 0);
    wr(8'h70, 1);
    for (int t = 0; t <= 63; t++) begin
      wr(8'h72, 64'(t)); settle();
      chk($sformatf("R9 threshold %0d", t), 64'(irq), (t == 0 || t > 5) ? 1 : 0);
    end
    wr(8'h72, 0); wr(8'h80, 0); settle();
    chk("R9 nothing pending", 64'(irq), 0);

    // R10 claim
    wr(8'h80, (64'd1 << 3) | (64'd1 << 7) | (64'd1 << 9));
    wr(8'hC0, (64'd1 << 7) | (64'd1 << 9));
    claim(); chk("R10 first claim", 64'(claim_id), 7);
    claim(); chk("R10 second claim", 64'(claim_id), 9);
    claim(); chk("R10 empty claim", 64'(claim_id), 0);
    rd(8'h80, v); chk("R10 pending after claims", v, 64'd1 << 3);

    // R11 message set against a same-cycle clear
    wr(8'h80, 64'd1 << 12);
    @(negedge clk);
    msi_we = 1'b1; msi_data = 32'd12;
    csr_req = 1'b1; csr_op = 3'd3; csr_wdata = 64'd1 << 12;
    @(negedge clk);
    msi_we = 1'b0; csr_req = 1'b0;
    rd(8'h80, v); chk("R11 set beats data clear", v, 64'd1 << 12);
    wr(8'h80, 0); wr(8'hC0, 64'd1 << 20);
    msi(32'd20); settle();
    @(negedge clk);
    claim_req = 1'b1; msi_we = 1'b1; msi_data = 32'd20;
    @(negedge clk);
    claim_req = 1'b0; msi_we = 1'b0;
    chk("R11 claim still returns id", 64'(claim_id), 20);
    rd(8'h80, v); chk("R11 set beats claim clear", v, 64'd1 << 20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule